// File: doc/BRIEF.md
# Serial Clock-Generator Load Sequencer

This block loads one 24-bit programming word into an external frequency synthesizer over a two-wire serial link with one clock line and one data line. A host places a 3-bit register-select code and a 21-bit divider word on the inputs and pulses a start strobe. The block then drives a fixed series of line states. The series begins with an unlock preamble, followed by a start marker and the 24 frame bits. Each frame bit is sent as a four-phase pattern that shows the complement of the bit before the bit itself. A stop marker ends the series.

Every line state is held for a number of system clocks taken from a hold-count input, so that setup and hold times at the synthesizer are met on a fast system clock. After the stop marker both lines rest high. The block then waits a settle period, set by a parameter, so that the synthesizer can lock. When the settle period ends, it pulses `done_o` for one cycle. The divider word is computed elsewhere.

Top module: `clkgen_load_seq`

## Requirements
- R1: After reset, and at any time `busy_o` is low, `ser_clk_o` and `ser_data_o` are both 1, and `done_o` is 0 after reset.
- R2: A start pulse seen while idle captures the frame word `{sel_i, div_i}`, with `sel_i` in frame bits [23:21] and `div_i` in bits [20:0]. `busy_o` is 1 from the next cycle on.
- R3: The first 12 line states, written as (data,clk), are six repetitions of (1,0) followed by (1,1).
- R4: The next 5 line states are (1,0), (0,0), (0,1), (0,0), (0,1).
- R5: The next 96 line states carry frame bits 0 to 23, least significant bit first. Each bit b uses the states (~b,1), (~b,0), (b,0), (b,1).
- R6: The last 3 line states of the frame are (1,1), (1,0), (1,1).
- R7: Each line state is held for H system clocks, where H is the captured `hold_i`, and a value of 0 is treated as 1. The first state appears in the cycle after the start edge.
- R8: After the last stop state, both lines are 1 and `busy_o` stays 1 for SETTLE cycles. Then `done_o` is 1 for exactly one cycle, with `busy_o` 0.
- R9: A start pulse while `busy_o` is 1 is ignored, and the frame in progress is unchanged.
- R10: Changing `hold_i` or the frame inputs while busy has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| sel_i | input | 3 | Register-select code, placed in frame bits [23:21] |
| div_i | input | 21 | Divider word, placed in frame bits [20:0] |
| hold_i | input | 16 | System clocks per line state (0 treated as 1) |
| ser_clk_o | output | 1 | Serial clock line to the synthesizer |
| ser_data_o | output | 1 | Serial data line to the synthesizer |
| busy_o | output | 1 | High while a frame or the settle wait is in progress |
| done_o | output | 1 | One-cycle pulse when the settle wait ends |

## Verification
The bench predicts the full line waveform, cycle by cycle, for several frames and compares it with the outputs.

- **Alternating word (`0x0A5A5A`, select 2, hold 2):** shows whether the bit order and the complement-first phase order are right.
- **All-ones word (select 7, hold 1):** the first data phase repeats the last start state, so the line does not change at that point. This exposes any design that advances on edges instead of counting.
- **All-zeros word with hold 0:** checks that a hold of 0 is treated as 1.
- **Hold-3 frame with a second start and new input values mid-frame:** must come out unchanged, which separates a locked frame from one that reloads while busy.

// File: rtl/clkgen_load_pkg.sv
// Package: shared widths, line-state type and sequencer states for the
// serial clock-generator load sequencer. Assumes a 24-bit frame.
package clkgen_load_pkg;
    localparam int SEL_W      = 3;
    localparam int DIV_W      = 21;
    localparam int FRAME_W    = SEL_W + DIV_W;
    localparam int PRE_PAIRS  = 6;
    localparam int PRE_LEN    = PRE_PAIRS * 2;
    localparam int MARK_LEN   = 5;
    localparam int PHASES     = 4;
    localparam int DATA_LEN   = FRAME_W * PHASES;
    localparam int STOP_LEN   = 3;
    localparam int TOTAL_LEN  = PRE_LEN + MARK_LEN + DATA_LEN + STOP_LEN;
    localparam int LAST_STEP  = TOTAL_LEN - 1;
    localparam int STEP_W     = $clog2(TOTAL_LEN);
    localparam int DATA_IDX_W = $clog2(DATA_LEN);

    typedef struct packed {
        logic data;
        logic sclk;
    } line_t;

    localparam line_t LINE_IDLE = '{data: 1'b1, sclk: 1'b1};

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_SETTLE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/clkgen_load_counter.sv
// Module: clkgen_load_counter
// Wrapping counter that counts enabled cycles from 0 up to limit_i-1 and
// flags the final count. Assumes limit_i is at least 1 whenever en_i is high.
module clkgen_load_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    // Final count of the current window.
    assign last_o = (cnt_q == limit_i - CNT_W'(1));

    // Count up while enabled, wrap at the limit, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            if (last_o) cnt_q <= '0;
            else        cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (cnt_q < limit_i)); // R7
endmodule

// File: rtl/clkgen_load_pattern.sv
// Module: clkgen_load_pattern
// Maps a step index of the serial frame onto the (data, clock) line state:
// unlock preamble, start marker, four-phase data bits LSB first, stop marker.
// Pure combinational; assumes step_i never exceeds LAST_STEP.
module clkgen_load_pattern
    import clkgen_load_pkg::*;
(
    input  logic [STEP_W-1:0]  step_i,
    input  logic [FRAME_W-1:0] frame_i,
    output line_t              line_o
);
    localparam int MARK_BASE = PRE_LEN;
    localparam int DATA_BASE = PRE_LEN + MARK_LEN;
    localparam int STOP_BASE = DATA_BASE + DATA_LEN;

    logic [DATA_LEN-1:0] enc_data;
    logic [DATA_LEN-1:0] enc_clk;

    // Expand each frame bit into its complement-first four-phase pattern.
    for (genvar b = 0; b < FRAME_W; b++) begin : g_bit
        assign enc_data[b*PHASES + 0] = ~frame_i[b];
        assign enc_data[b*PHASES + 1] = ~frame_i[b];
        assign enc_data[b*PHASES + 2] =  frame_i[b];
        assign enc_data[b*PHASES + 3] =  frame_i[b];
        assign enc_clk [b*PHASES + 0] = 1'b1;
        assign enc_clk [b*PHASES + 1] = 1'b0;
        assign enc_clk [b*PHASES + 2] = 1'b0;
        assign enc_clk [b*PHASES + 3] = 1'b1;
    end

    logic [DATA_IDX_W-1:0] data_idx;
    logic [2:0]            mark_idx;
    logic [1:0]            stop_idx;

    // Offsets of the step inside the marker, data and stop segments.
    assign data_idx = DATA_IDX_W'(step_i - STEP_W'(DATA_BASE));
    assign mark_idx = 3'(step_i - STEP_W'(MARK_BASE));
    assign stop_idx = 2'(step_i - STEP_W'(STOP_BASE));

    // Select the segment the step falls into and produce its line state.
    always_comb begin
        line_o = LINE_IDLE;
        if (step_i < STEP_W'(MARK_BASE)) begin
            line_o.data = 1'b1;
            line_o.sclk = step_i[0];
        end else if (step_i < STEP_W'(DATA_BASE)) begin
            line_o.data = (mark_idx == 3'd0);
            line_o.sclk = (mark_idx == 3'd2) || (mark_idx == 3'd4);
        end else if (step_i < STEP_W'(STOP_BASE)) begin
            line_o.data = enc_data[data_idx];
            line_o.sclk = enc_clk[data_idx];
        end else begin
            line_o.data = 1'b1;
            line_o.sclk = (stop_idx != 2'd1);
        end
    end
endmodule

// File: rtl/clkgen_load_seq.sv
// Module: clkgen_load_seq (top)
// Loads one 24-bit word {select, divider} into an external synthesizer over
// a two-wire serial link, holds each line state for a captured number of
// clocks, waits SETTLE cycles, then pulses done. Assumes SETTLE >= 1.
module clkgen_load_seq
    import clkgen_load_pkg::*;
#(
    parameter int HOLD_W = 16,
    parameter int SETTLE = 12_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              ser_clk_o,
    output logic              ser_data_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int SETTLE_W = $clog2(SETTLE + 1);

    seq_state_e         state_q;
    logic [STEP_W-1:0]  step_q;
    logic [FRAME_W-1:0] frame_q;
    logic [HOLD_W-1:0]  hold_q;
    line_t              line_q;
    logic               done_q;

    logic               accept;
    logic [FRAME_W-1:0] frame_in;
    logic [HOLD_W-1:0]  hold_in;
    logic [STEP_W-1:0]  pat_step;
    logic [FRAME_W-1:0] pat_frame;
    line_t              pat_line;
    logic               hold_last;
    logic               settle_last;

    // Start is taken only while idle.
    assign accept   = (state_q == ST_IDLE) && start_i;
    assign frame_in = {sel_i, div_i};
    assign hold_in  = (hold_i == '0) ? HOLD_W'(1) : hold_i;

    // Pattern looks up the first step on accept, else the next step.
    assign pat_step  = (state_q == ST_IDLE) ? '0 : step_q + STEP_W'(1);
    assign pat_frame = (state_q == ST_IDLE) ? frame_in : frame_q;

    clkgen_load_pattern u_pattern (
        .step_i  (pat_step),
        .frame_i (pat_frame),
        .line_o  (pat_line)
    );

    clkgen_load_counter #(.CNT_W(HOLD_W)) u_hold_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .en_i    (state_q == ST_SHIFT),
        .limit_i (hold_q),
        .last_o  (hold_last)
    );

    clkgen_load_counter #(.CNT_W(SETTLE_W)) u_settle_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state_q != ST_SETTLE),
        .en_i    (state_q == ST_SETTLE),
        .limit_i (SETTLE_W'(SETTLE)),
        .last_o  (settle_last)
    );

    // Sequencer: capture on start, step through the frame, settle, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            frame_q <= '0;
            hold_q  <= HOLD_W'(1);
            line_q  <= LINE_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_SHIFT;
                        step_q  <= '0;
                        frame_q <= frame_in;
                        hold_q  <= hold_in;
                        line_q  <= pat_line;
                    end
                end
                ST_SHIFT: begin
                    if (hold_last) begin
                        if (step_q == STEP_W'(LAST_STEP)) begin
                            state_q <= ST_SETTLE;
                            line_q  <= LINE_IDLE;
                        end else begin
                            step_q <= step_q + STEP_W'(1);
                            line_q <= pat_line;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (settle_last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ser_clk_o  = line_q.sclk;
    assign ser_data_o = line_q.data;
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;

    AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ser_clk_o && ser_data_o)); // R1
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o); // R2
    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= STEP_W'(LAST_STEP)); // R5
    AST_LINES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !hold_last) |=> $stable(line_q)); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(state_q == ST_SETTLE)); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(frame_q)); // R9
    AST_HOLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(hold_q)); // R10
endmodule

// File: tb/clkgen_load_seq_tb_top.sv
`timescale 1ns/1ps
module clkgen_load_seq_tb_top;
    localparam int TB_SETTLE = 20;
    localparam int CLK_HALF  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  sel_i = '0;
    logic [20:0] div_i = '0;
    logic [15:0] hold_i = 16'd1;
    logic        ser_clk_o, ser_data_o, busy_o, done_o;

    int checks = 0;
    int errors = 0;

    // Scoreboard: each item is {data, clk, busy, done} expected for one cycle.
    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_HALF) clk = ~clk;

    clkgen_load_seq #(.HOLD_W(16), .SETTLE(TB_SETTLE)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .sel_i      (sel_i),
        .div_i      (div_i),
        .hold_i     (hold_i),
        .ser_clk_o  (ser_clk_o),
        .ser_data_o (ser_data_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {data,clk,busy,done} actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push_n(input logic d, input logic c, input int h, input string req);
        for (int i = 0; i < h; i++) begin
            exp_q.push_back({d, c, 1'b1, 1'b0});
            tag_q.push_back(req);
        end
    endtask

    // Driver: start a frame and push its whole expected waveform.
    task automatic run_frame(input logic [2:0] sel, input logic [20:0] div, input logic [15:0] hold);
        logic [23:0] frame;
        int h;
        frame = {sel, div};                              // R2: select above divider
        h = (hold == 0) ? 1 : int'(hold);                // R7: hold 0 acts as 1
        @(negedge clk);
        sel_i = sel; div_i = div; hold_i = hold; start_i = 1'b1;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        for (int p = 0; p < 6; p++) begin                // R3 preamble
            push_n(1'b1, 1'b0, h, "R3");
            push_n(1'b1, 1'b1, h, "R3");
        end
        push_n(1'b1, 1'b0, h, "R4");                     // R4 start marker
        push_n(1'b0, 1'b0, h, "R4");
        push_n(1'b0, 1'b1, h, "R4");
        push_n(1'b0, 1'b0, h, "R4");
        push_n(1'b0, 1'b1, h, "R4");
        for (int b = 0; b < 24; b++) begin               // R5 LSB first, four phases
            push_n(~frame[b], 1'b1, h, "R5");
            push_n(~frame[b], 1'b0, h, "R5");
            push_n( frame[b], 1'b0, h, "R5");
            push_n( frame[b], 1'b1, h, "R5");
        end
        push_n(1'b1, 1'b1, h, "R6");                     // R6 stop marker
        push_n(1'b1, 1'b0, h, "R6");
        push_n(1'b1, 1'b1, h, "R6");
        push_n(1'b1, 1'b1, TB_SETTLE, "R8");             // R8 settle, lines high
        exp_q.push_back(4'b1101);                        // R8 done pulse, not busy
        tag_q.push_back("R8");
    endtask

    task automatic drain_and_idle();
        wait (exp_q.size() == 0);
        @(negedge clk);
        @(negedge clk);
        check("R1", {ser_data_o, ser_clk_o, busy_o, done_o}, 4'b1100);
    endtask

    // Monitor: pop one expected item per cycle, sampled at the falling edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), {ser_data_o, ser_clk_o, busy_o, done_o}, exp_q.pop_front());
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                check("R1", {ser_data_o, ser_clk_o, busy_o, done_o}, 4'b1100);
                rst_n = 1'b1;
                @(negedge clk);
                check("R1", {ser_data_o, ser_clk_o, busy_o, done_o}, 4'b1100);

                run_frame(3'd2, 21'h0A5A5A, 16'd2);
                drain_and_idle();
                run_frame(3'd7, 21'h1FFFFF, 16'd1);
                drain_and_idle();
                run_frame(3'd0, 21'h000000, 16'd0);
                drain_and_idle();

                // R9/R10: second start and changed inputs mid-frame are ignored.
                run_frame(3'd5, 21'h123456, 16'd3);
                repeat (40) @(negedge clk);
                sel_i = 3'd1; div_i = 21'h0F0F0F; hold_i = 16'd7; start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                repeat (150) @(negedge clk);
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                drain_and_idle();
            end
            begin
                repeat (200000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual hung expected finish");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule